// File: doc/BRIEF.md
# Quadword Direct-Path Forwarder

This block carries out a direct-transfer command taken from a 32-bit packet instruction stream. The command holds a quadword count and the slot it occupied inside its 128-bit instruction line. The block first checks that the command sat in the last slot of its line. It then waits until the upstream buffer holds every operand word the command needs. After that it packs the words, four at a time, into 128-bit quadwords and hands each quadword to the graphics-side output.

A count of zero stands for the largest possible block, `2^CNT_W` quadwords. A command in the wrong slot moves no data. It only raises a one-cycle error strobe.

Both data paths use valid/ready handshakes:
- A word transfers on the operand input in any cycle where `in_valid` and `in_ready` are both high.
- A quadword transfers on the output in any cycle where `out_valid` and `out_ready` are both high.
- While `out_ready` is low, a presented quadword stays put. The block keeps taking operand words until the next quadword is complete, then holds `in_ready` low until the output register is free.
- The upstream side may drop `in_valid` at any time.

When the last quadword has been accepted, a completion strobe reports how far the instruction pointer advances. The command signals and `avail_words` are plain control pins.

Top module: `dqf_direct_fwd`

## Requirements
- R1: Out of reset, `cmd_ready` is 1 and `in_ready`, `out_valid`, `err` and `done` are all 0.
- R2: A command accepted with `cmd_slot` other than 3 (the last of the four slots) makes `err` high for exactly the one cycle after acceptance. The block stays ready for a new command.
- R3: A zero `cmd_imm` means `2^CNT_W` quadwords. Any other value means that many quadwords.
- R4: No operand word is taken (`in_ready` stays 0) until `avail_words` is at least four times the quadword count.
- R5: A legal command takes exactly four operand words per quadword. Once the last one has been taken, `in_ready` stays 0.
- R6: The k-th operand word after the command (counting from 0) appears in bits `[32*(k%4) +: 32]` of output quadword `k/4`. Quadwords leave in order.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R8: `done` pulses for one cycle, the cycle after the last quadword is accepted. During that pulse `pc_advance` equals 1 + 4 × count and `out_valid` is 0.
- R9: `cmd_ready` is 0 from the acceptance of a legal command until its `done` pulse. Any `cmd_valid` seen in that time is ignored.
- R10: A rejected command produces no output quadword and takes no operand word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to accept a command |
| cmd_imm | input | CNT_W | Quadword count; zero means 2^CNT_W |
| cmd_slot | input | 2 | Word slot the command occupied in its instruction line |
| avail_words | input | CNT_W+3 | Operand words already buffered upstream after the command |
| in_valid | input | 1 | Operand word valid |
| in_ready | output | 1 | Operand word accepted this cycle when valid |
| in_data | input | 32 | Operand word |
| out_valid | output | 1 | Quadword valid |
| out_ready | input | 1 | Downstream accepts the quadword |
| out_data | output | 128 | Packed quadword, lane 0 in the low bits |
| err | output | 1 | One-cycle misaligned-command strobe |
| done | output | 1 | One-cycle completion strobe |
| pc_advance | output | CNT_W+3 | Instruction-pointer advance, valid while `done` is high |

## Verification
Faults inside the block show up at the ports quickly:
- A corrupted lane counter or lane register shows as a wrong word inside the next quadword, at most four accepted words later.
- A wrong remaining-word count shows up in two ways. Either `in_ready` stays high after the expected last word, or `done` never arrives and `out_valid` stays low.
- A broken start gate shows as `in_ready` rising while `avail_words` is still short.
- A misdecoded zero count changes `pc_advance` and the number of quadwords.

The reference model therefore compares data on every output handshake and checks the gating and the over-consumption condition every clock.

// File: rtl/dqf_pkg.sv
package dqf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } dqf_state_e;
endpackage

// File: rtl/dqf_decode.sv
// Command decode: slot alignment check and quadword/word count expansion.
module dqf_decode #(
  parameter int CNT_W  = 16,
  parameter int LANE_W = 2,
  parameter int AV_W   = CNT_W + 1 + LANE_W
) (
  input  logic [CNT_W-1:0]  imm,
  input  logic [LANE_W-1:0] slot,
  output logic              aligned,
  output logic [AV_W-1:0]   word_count
);
  localparam logic [LANE_W-1:0] LAST_SLOT = '1;

  logic [CNT_W:0] qw_count;

  always_comb begin
    aligned = (slot == LAST_SLOT);
    if (imm == '0) qw_count = {1'b1, {CNT_W{1'b0}}};
    else           qw_count = {1'b0, imm};
    word_count = AV_W'(qw_count) << LANE_W;
  end
endmodule

// File: rtl/dqf_pack.sv
// Lane assembly: gathers operand words into a quadword and holds it for output.
module dqf_pack #(
  parameter int WORD_W = 32,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_fire,
  input  logic [WORD_W-1:0]       in_data,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [WORD_W*LANES-1:0] out_data,
  output logic                    lane_blocked
);
  localparam int LANE_W = $clog2(LANES);
  localparam int QW_W   = WORD_W * LANES;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic [LANE_W-1:0]               lane_q;
  logic [LANES-2:0][WORD_W-1:0]    hold_q;
  logic [QW_W-1:0]                 assembled;
  logic                            load;
  logic                            valid_q;
  logic [QW_W-1:0]                 data_q;

  assign load      = in_fire && (lane_q == LAST_LANE);
  assign assembled = {in_data, hold_q};

  always_ff @(posedge clk) begin
    if (!rst_n)       lane_q <= '0;
    else if (in_fire) lane_q <= (lane_q == LAST_LANE) ? '0 : lane_q + 1'b1;
  end

  for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                                       hold_q[g] <= '0;
      else if (in_fire && lane_q == LANE_W'(g))         hold_q[g] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= assembled;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid    = valid_q;
  assign out_data     = data_q;
  assign lane_blocked = (lane_q == LAST_LANE) && valid_q;

  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !load);
endmodule

// File: rtl/dqf_ctrl.sv
// Transfer sequencing: accept/reject, start gate, word countdown, drain, completion.
module dqf_ctrl
  import dqf_pkg::*;
#(
  parameter int AV_W = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic            aligned,
  input  logic [AV_W-1:0] word_count,
  input  logic [AV_W-1:0] avail_words,
  input  logic            word_fire,
  input  logic            out_fire,
  input  logic            out_valid,
  output logic            cmd_ready,
  output logic            run,
  output logic            err,
  output logic            done,
  output logic [AV_W-1:0] pc_advance
);
  localparam logic [AV_W-1:0] ONE = AV_W'(1);

  dqf_state_e      state_q;
  logic [AV_W-1:0] left_q;
  logic [AV_W-1:0] pc_q;
  logic            err_q;
  logic            done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      pc_q    <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (!aligned) begin
              err_q <= 1'b1;
            end else begin
              left_q  <= word_count;
              pc_q    <= word_count + ONE;
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (avail_words >= left_q) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (word_fire) begin
            left_q <= left_q - ONE;
            if (left_q == ONE) state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (out_fire) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (state_q == ST_IDLE);
  assign run        = (state_q == ST_RUN);
  assign err        = err_q;
  assign done       = done_q;
  assign pc_advance = pc_q;

  a_r5_no_extra_word: assert property (@(posedge clk) disable iff (!rst_n)
    word_fire |-> (left_q != '0));

  a_r8_drain_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |-> out_valid);

  a_r8_done_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && cmd_ready));

  a_r2_reject_moves_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!run && !out_valid));

  a_r4_wait_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> !word_fire);
endmodule

// File: rtl/dqf_direct_fwd.sv
// Direct-transfer quadword forwarder top level.
module dqf_direct_fwd #(
  parameter int CNT_W  = 16,
  parameter int WORD_W = 32,
  parameter int LANES  = 4,
  localparam int LANE_W = $clog2(LANES),
  localparam int QW_W   = WORD_W * LANES,
  localparam int AV_W   = CNT_W + 1 + LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CNT_W-1:0]  cmd_imm,
  input  logic [LANE_W-1:0] cmd_slot,
  input  logic [AV_W-1:0]   avail_words,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [QW_W-1:0]   out_data,
  output logic              err,
  output logic              done,
  output logic [AV_W-1:0]   pc_advance
);
  logic            aligned;
  logic [AV_W-1:0] word_count;
  logic            run;
  logic            lane_blocked;
  logic            word_fire;
  logic            out_fire;

  assign in_ready  = run && !lane_blocked;
  assign word_fire = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;

  dqf_decode #(.CNT_W(CNT_W), .LANE_W(LANE_W), .AV_W(AV_W)) i_decode (
    .imm        (cmd_imm),
    .slot       (cmd_slot),
    .aligned    (aligned),
    .word_count (word_count)
  );

  dqf_ctrl #(.AV_W(AV_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .aligned     (aligned),
    .word_count  (word_count),
    .avail_words (avail_words),
    .word_fire   (word_fire),
    .out_fire    (out_fire),
    .out_valid   (out_valid),
    .cmd_ready   (cmd_ready),
    .run         (run),
    .err         (err),
    .done        (done),
    .pc_advance  (pc_advance)
  );

  dqf_pack #(.WORD_W(WORD_W), .LANES(LANES)) i_pack (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_fire      (word_fire),
    .in_data      (in_data),
    .out_ready    (out_ready),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .lane_blocked (lane_blocked)
  );

  a_r9_busy_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && cmd_valid) |=> !err);

  a_r4_ready_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cmd_ready);
endmodule

// File: tb/test_dqf_direct_fwd.sv
module test_dqf_direct_fwd;
  localparam int CNT_W = 4;
  localparam int AV_W  = CNT_W + 3;
  localparam int QW_W  = 128;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic             cmd_valid;
  logic             cmd_ready;
  logic [CNT_W-1:0] cmd_imm;
  logic [1:0]       cmd_slot;
  logic [AV_W-1:0]  avail_words;
  logic             in_valid;
  logic             in_ready;
  logic [31:0]      in_data;
  logic             out_valid;
  logic             out_ready;
  logic [QW_W-1:0]  out_data;
  logic             err;
  logic             done;
  logic [AV_W-1:0]  pc_advance;

  dqf_direct_fwd #(.CNT_W(CNT_W)) i_dqf_direct_fwd (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_imm(cmd_imm), .cmd_slot(cmd_slot), .avail_words(avail_words),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .err(err), .done(done), .pc_advance(pc_advance)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // reference model state
  int              feed_total = 0;
  int              feed_idx   = 0;
  int              need_words = 0;
  int              seed       = 0;
  bit              gaps       = 0;
  bit              stalls     = 0;
  logic [QW_W-1:0] expq[$];
  logic [15:0]     lfsr = 16'hACE1;
  bit              prev_stall = 0;
  logic [QW_W-1:0] prev_data  = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [QW_W-1:0] act, input logic [QW_W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int s, input int k);
    return {s[15:0], k[15:0]};
  endfunction

  function automatic void finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endfunction

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
      finish_run();
    end
  end

  // per-clock reference comparison and stream driving
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      // R7: a stalled quadword stays valid and unchanged
      if (prev_stall) begin
        chk(out_valid, "R7", "valid dropped under stall", QW_W'(out_valid), 1);
        chk(out_data == prev_data, "R7", "data changed under stall", out_data, prev_data);
      end
      out_ready = stalls ? lfsr[0] : 1'b1;
      // R10: no quadword beyond what the model expects
      if (out_valid && expq.size() == 0)
        chk(1'b0, "R10", "unexpected quadword", out_data, '0);
      if (out_valid && out_ready && expq.size() != 0) begin
        chk(out_data == expq[0], "R6", "quadword content", out_data, expq[0]);
        void'(expq.pop_front());
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      // R4: no word before enough is buffered
      if (in_ready)
        chk(int'(avail_words) >= need_words, "R4", "in_ready before enough words",
            QW_W'(avail_words), QW_W'(need_words));
      // R5: no request for words past the count
      if (in_ready)
        chk(feed_idx < feed_total, "R5", "in_ready after last word",
            QW_W'(feed_idx), QW_W'(feed_total));
      if (feed_idx < feed_total) begin
        in_valid = gaps ? lfsr[1] : 1'b1;
        in_data  = word_of(seed, feed_idx);
      end else begin
        in_valid = 1'b0;
        in_data  = '0;
      end
      if (in_valid && in_ready) feed_idx++;
    end
  end

  task automatic do_cmd(input int imm, input int slot, input int avail,
                        input bit g, input bit s, input int sd);
    int n;
    bit legal;
    n     = (imm == 0) ? (1 << CNT_W) : imm;   // R3
    legal = (slot == 3);
    @(negedge clk);
    chk(cmd_ready, "R9", "cmd_ready before command", QW_W'(cmd_ready), 1);
    gaps = g; stalls = s; seed = sd;
    expq.delete();
    if (legal) begin
      for (int q = 0; q < n; q++)
        expq.push_back({word_of(sd, 4*q+3), word_of(sd, 4*q+2),
                        word_of(sd, 4*q+1), word_of(sd, 4*q)});
      need_words = 4 * n;
      feed_total = 4 * n;
    end else begin
      need_words = 1 << 30;
      feed_total = 4 * n;
    end
    feed_idx    = 0;
    cmd_valid   = 1'b1;
    cmd_imm     = CNT_W'(imm);
    cmd_slot    = 2'(slot);
    avail_words = AV_W'(avail);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!legal) begin
      chk(err, "R2", "err after misaligned command", QW_W'(err), 1);
      @(negedge clk);
      chk(!err, "R2", "err longer than one cycle", QW_W'(err), 0);
      chk(cmd_ready, "R2", "ready after reject", QW_W'(cmd_ready), 1);
      repeat (8) @(negedge clk);
      chk(feed_idx == 0, "R10", "words taken by rejected command", QW_W'(feed_idx), 0);
      chk(!out_valid, "R10", "output after reject", QW_W'(out_valid), 0);
      feed_total = 0;
      need_words = 0;
      return;
    end
    chk(!err, "R2", "err on aligned command", QW_W'(err), 0);
    chk(!cmd_ready, "R9", "cmd_ready while busy", QW_W'(cmd_ready), 0);
    // R9: misaligned command while busy must be ignored
    cmd_valid = 1'b1;
    cmd_slot  = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(!err, "R9", "busy command not ignored", QW_W'(err), 0);
    if (avail < 4 * n) begin
      repeat (20) @(negedge clk);
      chk(feed_idx == 0, "R4", "words taken while short", QW_W'(feed_idx), 0);
      avail_words = AV_W'(4 * n);
    end
    for (int t = 0; t < 5000 && !done; t++) @(negedge clk);
    chk(done, "R8", "done pulse", QW_W'(done), 1);
    chk(pc_advance == AV_W'(1 + 4 * n), "R8", "pc_advance", QW_W'(pc_advance),
        QW_W'(1 + 4 * n));
    chk(expq.size() == 0, "R8", "quadwords left at done", QW_W'(expq.size()), 0);
    chk(feed_idx == 4 * n, "R5", "words consumed", QW_W'(feed_idx), QW_W'(4 * n));
    chk(!out_valid, "R8", "out_valid at done", QW_W'(out_valid), 0);
    @(negedge clk);
    chk(!done, "R8", "done longer than one cycle", QW_W'(done), 0);
    chk(cmd_ready, "R9", "ready after done", QW_W'(cmd_ready), 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_imm = '0; cmd_slot = '0;
    avail_words = '0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready, "R1", "cmd_ready", QW_W'(cmd_ready), 1);
    chk(!in_ready, "R1", "in_ready", QW_W'(in_ready), 0);
    chk(!out_valid, "R1", "out_valid", QW_W'(out_valid), 0);
    chk(!err, "R1", "err", QW_W'(err), 0);
    chk(!done, "R1", "done", QW_W'(done), 0);
    do_cmd(2, 0, 100, 0, 0, 16'h0A01);     // R2 / R10 misaligned
    do_cmd(2, 1, 100, 0, 0, 16'h0A02);
    do_cmd(2, 2, 100, 0, 0, 16'h0A03);
    do_cmd(1, 3, 4, 0, 0, 16'h1001);       // single quadword
    do_cmd(3, 3, 12, 0, 1, 16'h2002);      // output stalls
    do_cmd(2, 3, 7, 0, 0, 16'h3003);       // R4 one word short
    do_cmd(0, 3, 64, 0, 0, 16'h4004);      // R3 zero count
    do_cmd(15, 3, 60, 1, 1, 16'h5005);     // gaps and stalls
    do_cmd(5, 3, 0, 1, 0, 16'h6006);       // start gated from empty
    finish_run();
  end
endmodule